// File: doc/BRIEF.md
# Guard-Round-Sticky Rounding Unit

This combinational stage rounds a mantissa held in a wide internal floating-point format. The input mantissa carries two extra low-order bits. The upper of the two is the guard bit and the lower is the round bit. A separate sticky bit summarises everything already shifted out below them. The stage drops the two extra bits and chooses, from the sign and a 2-bit rounding-mode field, whether to add one at the new least significant bit. It returns the truncated or incremented mantissa, a carry out of the top bit, a rounded-up flag and an inexact flag.

The stage does not renormalise. An increment that carries all the way through leaves a carry out and an all-zero mantissa, which is the value 2.0 when the top bit held the leading one. The consumer detects this through `carry_out` or `rounded_up`, and it adjusts the exponent itself.

Top module: `grs_round`

## Requirements
- R1: `mant_out` equals `mant_in` shifted right by two whenever no increment is made. The sticky input is only read and is never returned shifted.
- R2: When the guard bit (`mant_in[1]`), the round bit (`mant_in[0]`) and `sticky_in` are all zero, `inexact` is 0, `rounded_up` is 0 and `carry_out` is 0, in every mode.
- R3: When any of guard, round or sticky is 1, `inexact` is 1, in every mode.
- R4: With `rmode` = 2'b00 (nearest, ties to even), the stage increments exactly when guard is 1 and at least one of the following is 1: round, sticky, or the least significant bit of the shifted mantissa.
- R5: With `rmode` = 2'b01 (toward zero), the stage never increments.
- R6: With `rmode` = 2'b10 (toward plus infinity), the stage increments exactly when the result is inexact and `sign_in` is 0.
- R7: With `rmode` = 2'b11 (toward minus infinity), the stage increments exactly when the result is inexact and `sign_in` is 1.
- R8: An increment adds one at the LSB of the shifted mantissa and carries through its full width. An all-ones shifted mantissa yields `carry_out` = 1 and `mant_out` = 0.
- R9: `rounded_up` is 1 exactly when an increment is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mant_in | input | MANT_W | Mantissa with guard bit at [1] and round bit at [0] |
| sticky_in | input | 1 | OR of all bits previously shifted out |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| rmode | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_out | output | MANT_W-2 | Rounded mantissa with the guard and round bits removed |
| carry_out | output | 1 | Carry out of the top bit from the increment |
| rounded_up | output | 1 | 1 when an increment was applied |
| inexact | output | 1 | 1 when any discarded information was nonzero |

## Verification
The bench targets the nearest-mode tie, where guard is set and round and sticky are clear, using both even and odd LSBs. A design that rounds ties away from zero would increment the even case, and one that ignores the LSB would never increment the odd case. Other directed cases cover:
- sticky as the only nonzero input, which a design that forgets it would report as exact;
- directed modes with each sign, where a swapped sign test rounds the wrong way;
- an all-ones mantissa, where a carry chain cut short would lose `carry_out` or leave high bits set.

Random vectors across all four modes are compared against an integer reference.

// File: rtl/grs_round.sv
module grs_round #(
  parameter int MANT_W = 115
) (
  input  logic [MANT_W-1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        rmode,
  output logic [MANT_W-3:0] mant_out,
  output logic              carry_out,
  output logic              rounded_up,
  output logic              inexact
);
  localparam int OUT_W = MANT_W - 2;

  logic             guard_b;
  logic             round_b;
  logic [OUT_W-1:0] trunc;
  logic             bump;

  assign guard_b = mant_in[1];
  assign round_b = mant_in[0];
  assign trunc   = mant_in[MANT_W-1:2];
  assign inexact = guard_b | round_b | sticky_in;

  always_comb begin
    case (rmode)
      2'b01:   bump = 1'b0;
      2'b10:   bump = inexact & ~sign_in;
      2'b11:   bump = inexact & sign_in;
      default: bump = guard_b & (round_b | sticky_in | trunc[0]);
    endcase
  end

  assign {carry_out, mant_out} = {1'b0, trunc} + {{OUT_W{1'b0}}, bump};
  assign rounded_up = bump;

  always_comb begin
    // R2
    if (!(guard_b || round_b || sticky_in))
      exact_chk: assert (!rounded_up && !carry_out && mant_out == mant_in[MANT_W-1:2])
        else $error("exact input altered");
    // R5
    if (rmode == 2'b01)
      zero_mode_chk: assert (!rounded_up && mant_out == mant_in[MANT_W-1:2])
        else $error("toward-zero incremented");
    // R6
    if (rmode == 2'b10 && sign_in)
      pinf_neg_chk: assert (!rounded_up) else $error("+inf rounded a negative up");
    // R7
    if (rmode == 2'b11 && !sign_in)
      ninf_pos_chk: assert (!rounded_up) else $error("-inf rounded a positive up");
    // R8
    if (carry_out)
      carry_wrap_chk: assert (rounded_up && mant_out == '0) else $error("carry without wrap");
    // R9
    if (rounded_up)
      up_inexact_chk: assert (inexact) else $error("increment on exact input");
  end
endmodule

// File: tb/tb_grs_round.sv
module tb_grs_round;
  localparam int W = 115;
  localparam int OW = W - 2;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0]  mant_in;
  logic          sticky_in, sign_in;
  logic [1:0]    rmode;
  logic [OW-1:0] mant_out;
  logic          carry_out, rounded_up, inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  grs_round #(.MANT_W(W)) dut (
    .mant_in(mant_in), .sticky_in(sticky_in), .sign_in(sign_in), .rmode(rmode),
    .mant_out(mant_out), .carry_out(carry_out), .rounded_up(rounded_up), .inexact(inexact)
  );

  task automatic apply(input logic [W-1:0] m, input logic s, input logic sg,
                       input logic [1:0] md, input string tag);
    logic [OW:0] base, sum;
    logic g, r, lsb, inx, up;
    mant_in = m; sticky_in = s; sign_in = sg; rmode = md;
    @(negedge clk);
    base = {1'b0, m[W-1:2]};
    g = m[1]; r = m[0]; lsb = m[2];
    inx = g | r | s;
    case (md)
      2'b00:   up = g && (r || s || lsb);
      2'b01:   up = 1'b0;
      2'b10:   up = inx && !sg;
      default: up = inx && sg;
    endcase
    sum = base + (up ? 1 : 0);
    checks++;
    if ({carry_out, mant_out} !== sum || rounded_up !== up || inexact !== inx) begin
      errors++;
      $display("FAIL %s: got c=%0b m=%h up=%0b nx=%0b exp c=%0b m=%h up=%0b nx=%0b",
               tag, carry_out, mant_out, rounded_up, inexact, sum[OW], sum[OW-1:0], up, inx);
    end
  endtask

  function automatic logic [W-1:0] rnd_mant();
    logic [127:0] v;
    v = {$urandom, $urandom, $urandom, $urandom};
    return v[W-1:0];
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R2 exact in each mode
    for (int md = 0; md < 4; md++) apply({{(W-3){1'b1}}, 3'b100}, 1'b0, md[0], md[1:0], "R2 exact");
    // R1 shift only, toward zero with fraction bits set
    apply(rnd_mant() | 3, 1'b1, 1'b0, 2'b01, "R1 R5 truncate");
    // R3 sticky only
    for (int md = 0; md < 4; md++) apply({{(W-3){1'b0}}, 3'b000}, 1'b1, 1'b1, md[1:0], "R3 sticky only");
    // R4 ties
    apply({{(W-3){1'b0}}, 3'b010}, 1'b0, 1'b0, 2'b00, "R4 tie even stays");
    apply({{(W-3){1'b0}}, 3'b110}, 1'b0, 1'b0, 2'b00, "R4 tie odd rounds up");
    apply({{(W-3){1'b0}}, 3'b010}, 1'b1, 1'b1, 2'b00, "R4 above half via sticky");
    apply({{(W-3){1'b0}}, 3'b001}, 1'b1, 1'b0, 2'b00, "R4 below half");
    // R6 R7 signs
    apply({{(W-3){1'b0}}, 3'b001}, 1'b0, 1'b0, 2'b10, "R6 positive up");
    apply({{(W-3){1'b0}}, 3'b001}, 1'b0, 1'b1, 2'b10, "R6 negative stays");
    apply({{(W-3){1'b0}}, 3'b001}, 1'b0, 1'b1, 2'b11, "R7 negative up");
    apply({{(W-3){1'b0}}, 3'b001}, 1'b0, 1'b0, 2'b11, "R7 positive stays");
    // R8 full carry
    apply({W{1'b1}}, 1'b0, 1'b0, 2'b00, "R8 carry out");
    apply({W{1'b1}}, 1'b1, 1'b1, 2'b11, "R8 carry out minus");
    apply({{(W-6){1'b0}}, 6'b111110}, 1'b0, 1'b0, 2'b00, "R8 R9 partial carry");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      md = 2'($urandom);
      case (md)
        2'b00:   apply(rnd_mant(), 1'($urandom), 1'($urandom), md, "R4 R9 random nearest");
        2'b01:   apply(rnd_mant(), 1'($urandom), 1'($urandom), md, "R5 R1 random zero");
        2'b10:   apply(rnd_mant(), 1'($urandom), 1'($urandom), md, "R6 R3 random plus");
        default: apply(rnd_mant(), 1'($urandom), 1'($urandom), md, "R7 R8 random minus");
      endcase
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule